// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two two's-complement operands over several clock cycles, one multiplier bit per cycle. A host moves everything through one narrow data bus. A one-cycle `start` pulse begins an operation. The next two bus words are taken as the multiplicand and then the multiplier. The block then runs its add-or-skip and shift iterations on an accumulator / multiplier register pair, which shifts right as one unit. When the iterations are done it returns the double-width signed product as two words, most significant word first, and then raises `done` for one cycle.

The lower WIDTH-1 multiplier bits work as positive weights. The multiplier's sign bit is handled in one extra correction cycle, where the multiplicand is subtracted rather than added. This gives a correct signed product for every operand pair, with no pre-complementing of either operand. The adder has one guard bit above the operand width, so no partial product is lost. A sticky flag records whether any adder step produced a sum that does not fit the operand width.

Top module: `shiftadd_mul`

## Requirements
- R1: After reset `busy`, `out_valid`, `done` and `ovf` are 0 and `bus_out` is all zeros.
- R2: The first `bus_in` word after the `start` edge is taken as the multiplicand and the second as the multiplier. Swapping the two words gives the same product but can change `ovf`.
- R3: The returned 2*WIDTH-bit word equals the signed product of the two operands for every pair, including the most negative value, zero and the most positive value.
- R4: The product comes out on two consecutive cycles with `out_valid` high: the upper WIDTH bits first, then the lower WIDTH bits.
- R5: `out_valid` first rises after exactly WIDTH+2 rising edges counted from the edge that samples `start` (10 edges for WIDTH=8). It stays low before that.
- R6: `done` is high for exactly one cycle, the cycle right after the low word. `out_valid` is low in that cycle.
- R7: A `start` pulse while `busy` is high is ignored. The operation in progress keeps its operands, its result and its timing.
- R8: `ovf` clears when a `start` is accepted. It is set if any adder step gives a sum outside the signed WIDTH-bit range, taking the multiplier bits in order from least significant. It then holds its value until the next accepted `start`.
- R9: `bus_out` is all zeros whenever `out_valid` is low.
- R10: `busy` is high from the edge that accepts `start` until the cycle in which `done` is high, inclusive, and low after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin an operation |
| bus_in | input | WIDTH | Operand word: multiplicand, then multiplier |
| bus_out | output | WIDTH | Product word: upper half, then lower half |
| out_valid | output | 1 | `bus_out` carries a product word |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | An operation is in progress |
| ovf | output | 1 | Sticky adder overflow flag |

## Verification
The checker watches the output handshake on every cycle. It checks the one-cycle `done` pulse and where it falls, the two-beat `out_valid` burst, the quiet bus outside that burst, that `busy` cannot drop before `done`, and that `ovf` holds while idle. Only the bench scenarios can show the arithmetic: signed products and flag values across corner and random operand pairs, which word is taken as the multiplicand, the exact latency, and that a stray `start` in mid-operation leaves the result unchanged.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_MCAND,
        ST_LOAD_MPLIER,
        ST_ITERATE,
        ST_SIGN_FIX,
        ST_SEND_HI,
        ST_SEND_LO,
        ST_FINISH
    } mul_state_e;

    typedef struct packed {
        logic clear;     // zero accumulator and flag
        logic load_mc;   // capture multiplicand
        logic load_mp;   // capture multiplier
        logic step;      // add-or-skip then shift the pair
        logic negate;    // subtract instead of add (sign bit)
        logic send;      // drive a product word
        logic send_lo;   // pick the low word
    } dp_ctrl_t;

    function automatic logic is_busy(input mul_state_e st);
        return st != ST_IDLE;
    endfunction

endpackage

// File: rtl/mul_addsub.sv
module mul_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] operand,
    input  logic             enable,
    input  logic             subtract,
    output logic [WIDTH:0]   sum,
    output logic             range_err
);
    logic signed [WIDTH:0] acc_x;
    logic signed [WIDTH:0] opd_x;
    logic signed [WIDTH:0] addend;

    always_comb begin
        acc_x = {acc[WIDTH-1], acc};
        opd_x = {operand[WIDTH-1], operand};
        if (!enable)
            addend = '0;
        else if (subtract)
            addend = -opd_x;
        else
            addend = opd_x;
        sum       = acc_x + addend;
        range_err = enable && (sum[WIDTH] != sum[WIDTH-1]);
    end
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import shiftadd_mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output dp_ctrl_t   ctl,
    output mul_state_e state,
    output logic       busy,
    output logic       done
);
    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(WIDTH - 2);

    mul_state_e       state_q, state_d;
    logic [CNT_W-1:0] iter_q, iter_d;

    always_comb begin
        state_d = state_q;
        iter_d  = iter_q;
        ctl     = '0;
        unique case (state_q)
            ST_IDLE: if (start) begin
                ctl.clear = 1'b1;
                state_d   = ST_LOAD_MCAND;
            end
            ST_LOAD_MCAND: begin
                ctl.load_mc = 1'b1;
                state_d     = ST_LOAD_MPLIER;
            end
            ST_LOAD_MPLIER: begin
                ctl.load_mp = 1'b1;
                iter_d      = '0;
                state_d     = ST_ITERATE;
            end
            ST_ITERATE: begin
                ctl.step = 1'b1;
                if (iter_q == LAST_ITER)
                    state_d = ST_SIGN_FIX;
                else
                    iter_d = iter_q + 1'b1;
            end
            ST_SIGN_FIX: begin
                ctl.step   = 1'b1;
                ctl.negate = 1'b1;
                state_d    = ST_SEND_HI;
            end
            ST_SEND_HI: begin
                ctl.send = 1'b1;
                state_d  = ST_SEND_LO;
            end
            ST_SEND_LO: begin
                ctl.send    = 1'b1;
                ctl.send_lo = 1'b1;
                state_d     = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            state_q <= state_d;
            iter_q  <= iter_d;
        end
    end

    assign state = state_q;
    assign busy  = is_busy(state_q);
    assign done  = (state_q == ST_FINISH);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
    import shiftadd_mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  dp_ctrl_t         ctl,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             ovf
);
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] mplier_q;
    logic [WIDTH-1:0] mcand_q;
    logic             ovf_q;
    logic [WIDTH:0]   sum;
    logic             range_err;

    mul_addsub #(.WIDTH(WIDTH)) u_addsub (
        .acc       (acc_q),
        .operand   (mcand_q),
        .enable    (mplier_q[0]),
        .subtract  (ctl.negate),
        .sum       (sum),
        .range_err (range_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            mplier_q <= '0;
            mcand_q  <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (ctl.clear) begin
                acc_q <= '0;
                ovf_q <= 1'b0;
            end
            if (ctl.load_mc)
                mcand_q <= bus_in;
            if (ctl.load_mp)
                mplier_q <= bus_in;
            if (ctl.step) begin
                acc_q    <= sum[WIDTH:1];
                mplier_q <= {sum[0], mplier_q[WIDTH-1:1]};
                if (range_err)
                    ovf_q <= 1'b1;
            end
        end
    end

    always_comb begin
        if (!ctl.send)
            bus_out = '0;
        else if (ctl.send_lo)
            bus_out = mplier_q;
        else
            bus_out = acc_q;
    end

    assign ovf = ovf_q;
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
    import shiftadd_mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             out_valid,
    output logic             done,
    output logic             busy,
    output logic             ovf
);
    dp_ctrl_t   ctl;
    mul_state_e state;

    mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .state (state),
        .busy  (busy),
        .done  (done)
    );

    mul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .bus_in  (bus_in),
        .bus_out (bus_out),
        .ovf     (ovf)
    );

    assign out_valid = (state == ST_SEND_HI) || (state == ST_SEND_LO);
endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [WIDTH-1:0] bus_out,
    input logic             out_valid,
    input logic             done,
    input logic             busy,
    input logic             ovf
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                        // R6
    AST_DONE_AFTER_LO: assert property (@(posedge clk) disable iff (rst)
        done |-> (!out_valid && $past(out_valid)));              // R6
    AST_TWO_BEATS: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |=> out_valid);                         // R4
    AST_NO_THIRD_BEAT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |=> !out_valid);         // R4
    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (bus_out == '0));                         // R9
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);                               // R10
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);                                         // R10
    AST_OVF_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(ovf));                     // R8
    AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);                                     // R7
endmodule

bind shiftadd_mul shiftadd_mul_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .bus_out   (bus_out),
    .out_valid (out_valid),
    .done      (done),
    .busy      (busy),
    .ovf       (ovf)
);

// File: tb/shiftadd_mul_test.sv
module shiftadd_mul_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] bus_in = '0;
    logic [W-1:0] bus_out;
    logic         out_valid, done, busy, ovf;

    int n_checks = 0;
    int n_fails  = 0;
    int seed_dummy;

    always #2.5 clk = ~clk;

    shiftadd_mul #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .start(start), .bus_in(bus_in),
        .bus_out(bus_out), .out_valid(out_valid), .done(done),
        .busy(busy), .ovf(ovf)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Flag model: bits taken low first, guard-bit sums tested against W-bit range.
    function automatic bit ref_ovf(input logic signed [W-1:0] m, input logic [W-1:0] q);
        int p = 0;
        int s;
        bit v = 0;
        for (int i = 0; i < W - 1; i++) begin
            if (q[i]) begin
                s = p + int'(m);
                if (s > 127 || s < -128) v = 1;
                p = s;
            end
            p = p >>> 1;
        end
        if (q[W-1]) begin
            s = p - int'(m);
            if (s > 127 || s < -128) v = 1;
        end
        return v;
    endfunction

    task automatic run_op(input logic signed [W-1:0] m, input logic signed [W-1:0] q,
                          input bit inject);
        logic [2*W-1:0] exp_p;
        bit             exp_v;
        exp_p = 16'(int'(m) * int'(q));
        exp_v = ref_ovf(m, q);
        @(negedge clk); start = 1'b1; bus_in = 8'h5A;
        @(negedge clk); start = 1'b0; bus_in = m;
        check(busy == 1'b1, "R10", busy, 1);
        @(negedge clk); bus_in = q;
        @(negedge clk); bus_in = W'($urandom);
        for (int k = 3; k <= 9; k++) begin
            @(negedge clk);
            if (inject && k == 4) begin start = 1'b1; bus_in = W'($urandom); end
            if (k == 5) start = 1'b0;
            if (k == 9) check(out_valid == 1'b0, "R5", out_valid, 0);
        end
        @(negedge clk);
        check(out_valid == 1'b1, "R5", out_valid, 1);
        check(bus_out == exp_p[2*W-1:W], inject ? "R7" : "R3", bus_out, exp_p[2*W-1:W]);
        @(negedge clk);
        check(out_valid == 1'b1, "R4", out_valid, 1);
        check(bus_out == exp_p[W-1:0], inject ? "R7" : "R3", bus_out, exp_p[W-1:0]);
        @(negedge clk);
        check(done == 1'b1 && out_valid == 1'b0, "R6", {done, out_valid}, 2);
        check(bus_out == '0, "R9", bus_out, 0);
        check(ovf == exp_v, "R8", ovf, exp_v);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R10", {done, busy}, 0);
        check(ovf == exp_v, "R8", ovf, exp_v);
    endtask

    initial begin
        automatic logic signed [W-1:0] corners[6] = '{-128, -1, 0, 1, 127, -127};
        seed_dummy = $urandom(32'h1D2C3B4A);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && out_valid == 0 && done == 0, "R1", {busy, out_valid, done}, 0);
        check(bus_out == '0 && ovf == 0, "R1", {bus_out, ovf}, 0);

        // R2: operand order visible through the flag
        run_op(-128, -1, 0);
        run_op(-1, -128, 0);

        foreach (corners[i])
            foreach (corners[j])
                run_op(corners[i], corners[j], 0);

        // R7: stray start in mid-operation
        run_op(-77, 93, 1);
        run_op(127, -128, 1);

        for (int n = 0; n < 60; n++)
            run_op(W'($urandom), W'($urandom), (n % 7) == 0);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule